// File: doc/BRIEF.md
# Monochrome Video Sampling Timing Generator

This block produces sample strobes and pixel coordinates for digitizing the active picture of an interlaced monochrome video signal. An external sync separator supplies three signals: a single-cycle line-sync pulse, a single-cycle field-sync pulse and an odd/even field level. The block runs on the 50 MHz system clock and has no clock of its own for sampling. It marks every sample instant with a one-cycle strobe, and an analog-to-digital converter takes one intensity sample on each strobe.

After a field sync, a long delay runs out the blanking lines at the top of the field. Each accepted line sync then starts a short delay that skips the non-picture lead-in of that line. The sampling state follows. It emits one strobe every `CLK_DIV` system clocks until `SAMPLES` strobes have been given. Column and row indices and the field identity are valid together with each strobe. After `ROWS` complete lines the field is finished, so the trailing half line is never sampled.

The controller has five states. `ST_IDLE` waits for a field sync. `ST_SKIP` runs out the blanking lines. `ST_WAIT` waits for a line sync. `ST_LEAD` skips the line lead-in. `ST_SAMPLE` emits the strobes. The transitions are:
- field sync: any state to `ST_SKIP`.
- skip done: `ST_SKIP` to `ST_WAIT`.
- line accept: `ST_WAIT` to `ST_LEAD`.
- line restart: `ST_LEAD` or `ST_SAMPLE` to `ST_LEAD`, on a line sync.
- lead done: `ST_LEAD` to `ST_SAMPLE`.
- line done: `ST_SAMPLE` to `ST_WAIT`.
- field done: `ST_SAMPLE` to `ST_IDLE`, on the last row.

Top module: `vid_sample_timer`

## Requirements
- R1: After reset, `sample_stb_o`, `col_o`, `row_o` and `field_o` are all 0. Line syncs are ignored until a field sync arrives.
- R2: A field sync in cycle s accepted at edge s starts a blanking skip of `LINE_SKIP` cycles. No strobe is given during the skip, and line syncs that arrive before it ends are ignored.
- R3: A line sync accepted after the skip is followed by `LEAD_SKIP` cycles without a strobe. The first strobe of the line then appears with `col_o` = 0.
- R4: Within a line, strobes come exactly every `CLK_DIV` cycles. There are exactly `SAMPLES` of them, with `col_o` counting 0 to `SAMPLES`-1. `col_o` is 0 whenever no line is being sampled.
- R5: `row_o` starts at 0 for each field and increases by one after each line whose last strobe was given.
- R6: `field_o` takes the value of `field_odd_i` at each field sync and holds it until the next field sync.
- R7: A line sync that arrives while a line is in its lead-in or sampling abandons that line. No further strobe of the old line appears, `row_o` does not advance, and the lead-in restarts from that sync.
- R8: A field sync in any state takes priority over a line sync in the same cycle. It clears `row_o` and `col_o` and restarts the blanking skip.
- R9: After `ROWS` complete lines the field ends. `row_o` returns to 0, and no strobe is given on any line sync until the next field sync.
- R10: Between the end of one line and the next accepted line sync, no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_i | input | 1 | Line-sync pulse, one cycle, active high |
| field_sync_i | input | 1 | Field-sync pulse, one cycle, active high |
| field_odd_i | input | 1 | Odd/even field level from the sync separator |
| sample_stb_o | output | 1 | One-cycle strobe at each sample instant |
| col_o | output | COL_W (10) | Column index of the current sample |
| row_o | output | ROW_W (8) | Row index of the current line in the field |
| field_o | output | 1 | Field identity captured at the last field sync |

## Verification
The bench targets a line sync that lands inside the blanking skip. A design that accepted it would start sampling a blanking line. A second line sync arriving mid-line is also exercised. Mishandled, it would leave stale strobes, emit a partial row or advance the row count. The bench applies a field sync in the middle of sampling, which must clear the row at once. It also sends an extra line sync after the last row, which a design with an off-by-one row limit would sample as the half line. Every cycle is compared against a behavioural model, so a strobe that is one cycle early or late, a wrong divider phase or a 9th or 7th strobe in a line shows up as a mismatch.

// File: rtl/vst_pkg.sv
package vst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_WAIT,
        ST_LEAD,
        ST_SAMPLE
    } vst_state_e;

endpackage

// File: rtl/vst_span_counter.sv
// Delay counter: counts while run is high and flags the last cycle of a
// span of LIMIT cycles. A clear restarts the span and has priority.
module vst_span_counter #(
    parameter int LIMIT = 470
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/vst_pixel_step.sv
// Sample-rate divider and column counter for the active part of a line.
module vst_pixel_step #(
    parameter int CLK_DIV = 4,
    parameter int SAMPLES = 640,
    parameter int COL_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic             strobe,
    output logic             last,
    output logic [COL_W-1:0] col
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(SAMPLES - 1);

    logic [DIV_W-1:0] div_q;
    logic [COL_W-1:0] col_q;
    logic             phase_end;

    assign phase_end = (div_q == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            col_q <= '0;
        end else if (clear) begin
            div_q <= '0;
            col_q <= '0;
        end else if (run) begin
            if (phase_end) begin
                div_q <= '0;
                col_q <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign strobe = run && (div_q == '0);
    assign last   = run && phase_end && (col_q == COL_LAST);
    assign col    = col_q;
endmodule

// File: rtl/vid_sample_timer.sv
module vid_sample_timer
    import vst_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int LINE_SKIP = 55562,
    parameter int LEAD_SKIP = 470,
    parameter int SAMPLES   = 640,
    parameter int ROWS      = 242,
    parameter int COL_W     = 10,
    parameter int ROW_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_sync_i,
    input  logic             field_sync_i,
    input  logic             field_odd_i,
    output logic             sample_stb_o,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o,
    output logic             field_o
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    vst_state_e state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic             field_q;
    logic             in_line;
    logic             line_accept;
    logic             skip_done, lead_done;
    logic             pix_strobe, pix_last;
    logic [COL_W-1:0] pix_col;

    assign in_line     = (state_q == ST_WAIT) || (state_q == ST_LEAD) ||
                         (state_q == ST_SAMPLE);
    assign line_accept = line_sync_i && !field_sync_i && in_line;

    vst_span_counter #(.LIMIT(LINE_SKIP)) u_skip (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (field_sync_i),
        .run   (state_q == ST_SKIP),
        .done  (skip_done)
    );

    vst_span_counter #(.LIMIT(LEAD_SKIP)) u_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (line_accept || field_sync_i),
        .run   (state_q == ST_LEAD),
        .done  (lead_done)
    );

    vst_pixel_step #(
        .CLK_DIV (CLK_DIV),
        .SAMPLES (SAMPLES),
        .COL_W   (COL_W)
    ) u_pix (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (line_accept || field_sync_i),
        .run    (state_q == ST_SAMPLE),
        .strobe (pix_strobe),
        .last   (pix_last),
        .col    (pix_col)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (field_sync_i) begin
            state_d = ST_SKIP;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SKIP:   if (skip_done) state_d = ST_WAIT;
                ST_WAIT:   if (line_sync_i) state_d = ST_LEAD;
                ST_LEAD: begin
                    if (line_sync_i)    state_d = ST_LEAD;
                    else if (lead_done) state_d = ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (line_sync_i)   state_d = ST_LEAD;
                    else if (pix_last) state_d = (row_q == ROW_LAST) ? ST_IDLE : ST_WAIT;
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // row and field tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            field_q <= 1'b0;
        end else if (field_sync_i) begin
            row_q   <= '0;
            field_q <= field_odd_i;
        end else if (state_q == ST_SAMPLE && pix_last && !line_sync_i) begin
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sample_stb_o = pix_strobe;
        col_o        = pix_col;
        row_o        = row_q;
        field_o      = field_q;
    end
endmodule

// File: rtl/vst_checker.sv
module vst_checker #(
    parameter int CLK_DIV = 4,
    parameter int SAMPLES = 640,
    parameter int ROWS    = 242,
    parameter int COL_W   = 10,
    parameter int ROW_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_sync_i,
    input logic             field_sync_i,
    input logic             field_odd_i,
    input logic             sample_stb_o,
    input logic [COL_W-1:0] col_o,
    input logic [ROW_W-1:0] row_o,
    input logic             field_o
);
    p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> (int'(col_o) < SAMPLES));

    p_row_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_o) < ROWS);

    p_field_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_sync_i |=> (field_o == $past(field_odd_i)));

    p_field_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !field_sync_i |=> $stable(field_o));

    p_line_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync_i |=> (!sample_stb_o && col_o == '0));

    p_field_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        field_sync_i |=> (row_o == '0 && col_o == '0 && !sample_stb_o));

    generate
        if (CLK_DIV > 1) begin : g_gap
            p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                sample_stb_o |=> !sample_stb_o);
        end
    endgenerate
endmodule

bind vid_sample_timer vst_checker #(
    .CLK_DIV (CLK_DIV),
    .SAMPLES (SAMPLES),
    .ROWS    (ROWS),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W)
) u_vst_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_sync_i  (line_sync_i),
    .field_sync_i (field_sync_i),
    .field_odd_i  (field_odd_i),
    .sample_stb_o (sample_stb_o),
    .col_o        (col_o),
    .row_o        (row_o),
    .field_o      (field_o)
);

// File: tb/test_vid_sample_timer.sv
module test_vid_sample_timer;
    localparam int PERIOD    = 20;
    localparam int CLK_DIV   = 4;
    localparam int LINE_SKIP = 40;
    localparam int LEAD_SKIP = 6;
    localparam int SAMPLES   = 8;
    localparam int ROWS      = 4;
    localparam int COL_W     = 10;
    localparam int ROW_W     = 8;
    localparam int LINE_LEN  = 50;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hs = 1'b0, vs = 1'b0, odd = 1'b0;
    logic             smp;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             fld;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit finished = 1'b0;
    int strobe_tally = 0;

    vid_sample_timer #(
        .CLK_DIV(CLK_DIV), .LINE_SKIP(LINE_SKIP), .LEAD_SKIP(LEAD_SKIP),
        .SAMPLES(SAMPLES), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
    ) i_vid_sample_timer (
        .clk(clk), .rst_n(rst_n), .line_sync_i(hs), .field_sync_i(vs),
        .field_odd_i(odd), .sample_stb_o(smp), .col_o(col), .row_o(row),
        .field_o(fld)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference: phase 0 idle, 1 blanking, 2 between lines, 3 line
    longint cyc = 0, t0 = 0;
    int ph = 0, m_row = 0, m_fld = 0;
    int e_smp = 0, e_col = 0, e_row = 0, e_fld = 0;

    always @(posedge clk) begin
        longint k;
        cyc++;
        if (!rst_n) begin
            ph = 0; m_row = 0; m_fld = 0;
        end else if (vs) begin
            ph = 1; t0 = cyc; m_row = 0; m_fld = int'(odd);
        end else begin
            case (ph)
                1: if (cyc - t0 >= LINE_SKIP) ph = 2;
                2: if (hs) begin ph = 3; t0 = cyc; end
                3: begin
                    if (hs) t0 = cyc;
                    else if (cyc - t0 == LEAD_SKIP + SAMPLES*CLK_DIV) begin
                        if (m_row == ROWS-1) begin ph = 0; m_row = 0; end
                        else begin m_row++; ph = 2; end
                    end
                end
                default: ;
            endcase
        end
        k = cyc - t0 - LEAD_SKIP;
        e_smp = (ph == 3 && k >= 0 && (k % CLK_DIV) == 0) ? 1 : 0;
        e_col = (ph == 3 && k >= 0) ? int'(k / CLK_DIV) : 0;
        e_row = m_row;
        e_fld = m_fld;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check(int'(smp) == e_smp, "strobe", int'(smp), e_smp);
            check(int'(col) == e_col, "column", int'(col), e_col);
            check(int'(row) == e_row, "row", int'(row), e_row);
            check(int'(fld) == e_fld, "field", int'(fld), e_fld);
            if (smp) strobe_tally++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line_pulse();
        hs = 1'b1; @(negedge clk); hs = 1'b0;
    endtask

    task automatic field_pulse(input bit o);
        vs = 1'b1; odd = o; @(negedge clk); vs = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then line syncs before any field sync
        cur_req = "R1";
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        line_pulse();
        wait_cyc(60);
        check(strobe_tally == 0, "strobes before field sync", strobe_tally, 0);

        // R2 / R6: odd field, line sync inside blanking skip ignored
        cur_req = "R2";
        field_pulse(1'b1);
        wait_cyc(15);
        line_pulse();
        wait_cyc(LINE_SKIP);
        check(strobe_tally == 0, "strobes during blanking", strobe_tally, 0);

        // R3 / R4 / R5 / R9 / R10: full field of lines plus a trailing one
        cur_req = "R4";
        for (int i = 0; i < ROWS + 2; i++) begin
            line_pulse();
            wait_cyc(LINE_LEN - 1);
        end
        check(strobe_tally == ROWS*SAMPLES, "R9 strobes per field", strobe_tally, ROWS*SAMPLES);

        // R6 / R7: even field, abandoned line in mid sampling and in lead-in
        cur_req = "R7";
        strobe_tally = 0;
        field_pulse(1'b0);
        wait_cyc(LINE_SKIP + 3);
        line_pulse();
        wait_cyc(LEAD_SKIP + 9);
        line_pulse();
        wait_cyc(3);
        line_pulse();
        wait_cyc(LINE_LEN);
        line_pulse();
        wait_cyc(LINE_LEN);
        check(int'(row) == 2, "row after abandoned line", int'(row), 2);

        // R8: field sync and line sync together in mid sampling
        cur_req = "R8";
        line_pulse();
        wait_cyc(LEAD_SKIP + 10);
        hs = 1'b1; vs = 1'b1; odd = 1'b1;
        @(negedge clk);
        hs = 1'b0; vs = 1'b0;
        check(int'(row) == 0 && !smp, "row cleared by field sync", int'(row), 0);
        wait_cyc(LINE_SKIP + 2);
        cur_req = "R10";
        for (int i = 0; i < 2; i++) begin
            line_pulse();
            wait_cyc(LINE_LEN - 1);
        end
        wait_cyc(5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule